// File: doc/BRIEF.md
# Cross-Domain Protection Delay Timer

This block sets how long a high-current fault must persist before the protection path trips. Software writes a delay code into a small register in the CPU clock domain. The code is handed to a slow oscillator domain through a toggle handshake. While the handoff is in progress, a guard window makes the register refuse further writes, and a busy output shows that the window is open.

In the slow domain, a free-running prescaler divides the oscillator into fixed steps of `STEP_CYC` cycles each. When the protected switch is turned on (`switch_en`), detection stays disarmed for `INIT_CYC` slow cycles. After that, the fault input is measured in whole steps. Once the fault has lasted the selected number of steps, `trip` rises. It then stays high until the switch is turned off. Because the prescaler runs freely, the real reaction time falls in a window one step wide.

The delay code is 6 bits wide. Code n selects a window from (n-1) to n steps, and codes 0 and 1 share the shortest window.

Top module: `prot_delay_timer`

## Requirements
- R1: After reset, `rd_data` reads the initial code 0x01, `busy` is low and `trip` is low.
- R2: A write made while `busy` is low is stored. Bits 5:0 of `wr_data` form the code, and bits 7:6 always read as zero.
- R3: `busy` is high in the cycle after an accepted write. It stays high for at least 3 slow cycles plus 3 CPU cycles, then returns low by itself.
- R4: A write made while `busy` is high leaves `rd_data` unchanged.
- R5: With code n (n >= 1), the fault must stay high during at least (n-1)*STEP_CYC+1 and at most n*STEP_CYC slow clock edges before `trip` rises. Code 0 behaves the same as code 1.
- R6: For the first INIT_CYC slow edges after `switch_en` rises, the fault input is not measured and `trip` stays low.
- R7: When the fault input goes low before `trip` rises, the measurement restarts from zero.
- R8: Once high, `trip` stays high while `switch_en` is high, even if the fault goes away. It is low in the slow cycle after `switch_en` is seen low.
- R9: The top code 0x3F gives a window of 62 to 63 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU-side clock |
| rst_cpu_n | input | 1 | CPU-side asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data (bits 5:0 are the code) |
| rd_data | output | 8 | Register read value |
| busy | output | 1 | Guard window open: writes are ignored |
| clk_slow | input | 1 | Slow oscillator clock |
| rst_slow_n | input | 1 | Slow-side asynchronous reset, active low |
| switch_en | input | 1 | Protected switch is on (synchronous to clk_slow) |
| fault_in | input | 1 | Fault comparator output (synchronous to clk_slow) |
| trip | output | 1 | Protection trip request |

## Verification
The bench writes to the register while the guard window is open and checks that the register keeps its value. A design with no guard, or with a guard that is too short, would take the second value. It also checks `busy` both early and late in the window, which catches a window that closes before the slow side has the code or one that never closes.

Reaction time is measured for codes 0, 1, 2 and 0x3F against the one-step window. A design that treats code 0 as zero steps, or that counts the code one step too far, would trip outside that window. Further tests cover a fault that is high before the switch turns on, a fault made of pulses shorter than the window, and a fault that is removed after `trip` has risen. These catch a design that skips the initialization delay, one that keeps a partial count across fault drops, and one that releases `trip` too early or keeps it high after the switch is off.

// File: rtl/prot_delay_timer.sv
module prot_delay_timer #(
  parameter int          STEP_CYC  = 256,
  parameter int          INIT_CYC  = 25,
  parameter logic [5:0]  INIT_CODE = 6'h01
) (
  input  logic       clk_cpu,
  input  logic       rst_cpu_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       busy,
  input  logic       clk_slow,
  input  logic       rst_slow_n,
  input  logic       switch_en,
  input  logic       fault_in,
  output logic       trip
);
  localparam int PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam logic [PW-1:0] PRE_MAX  = PW'(STEP_CYC - 1);
  localparam logic [IW-1:0] INIT_MAX = IW'(INIT_CYC - 1);
  localparam logic [7:0]    RW_MASK  = 8'h3F;

  // CPU domain
  logic [7:0] reg_q;
  logic       req_tgl, ack_m, ack_s;
  logic [1:0] tail;
  logic       ack_tgl;

  always_ff @(posedge clk_cpu or negedge rst_cpu_n) begin
    if (!rst_cpu_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ack_tgl;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk_cpu or negedge rst_cpu_n) begin
    if (!rst_cpu_n) begin
      reg_q   <= {2'b00, INIT_CODE};
      req_tgl <= 1'b0;
      busy    <= 1'b0;
      tail    <= 2'd0;
    end else if (wr_en && !busy) begin
      reg_q   <= wr_data & RW_MASK;
      req_tgl <= ~req_tgl;
      busy    <= 1'b1;
      tail    <= 2'd0;
    end else if (busy && (ack_s == req_tgl)) begin
      if (tail == 2'd2) busy <= 1'b0;
      else              tail <= tail + 2'd1;
    end
  end

  assign rd_data = reg_q;

  // Slow domain
  logic          req_m, req_s;
  logic [5:0]    code_s;
  logic [PW-1:0] pre;
  logic [IW-1:0] init_cnt;
  logic          armed;
  logic [5:0]    run;
  logic          tick;
  logic [6:0]    eff;

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) begin
      req_m   <= 1'b0;
      req_s   <= 1'b0;
      ack_tgl <= 1'b0;
      code_s  <= INIT_CODE;
    end else begin
      req_m <= req_tgl;
      req_s <= req_m;
      if (req_s != ack_tgl) begin
        code_s  <= reg_q[5:0];
        ack_tgl <= req_s;
      end
    end
  end

  assign tick = (pre == PRE_MAX);
  assign eff  = (code_s < 6'd2) ? 7'd1 : {1'b0, code_s};

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) pre <= '0;
    else             pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) begin
      init_cnt <= '0;
      armed    <= 1'b0;
      run      <= 6'd0;
      trip     <= 1'b0;
    end else if (!switch_en) begin
      init_cnt <= '0;
      armed    <= 1'b0;
      run      <= 6'd0;
      trip     <= 1'b0;
    end else if (!armed) begin
      if (init_cnt == INIT_MAX) armed <= 1'b1;
      else                      init_cnt <= init_cnt + 1'b1;
    end else if (!trip) begin
      if (!fault_in) run <= 6'd0;
      else if (tick) begin
        if ({1'b0, run} + 7'd1 >= eff) trip <= 1'b1;
        else                           run  <= run + 6'd1;
      end
    end
  end
endmodule

// File: rtl/prot_delay_timer_chk.sv
module prot_delay_timer_chk (
  input logic       clk_cpu,
  input logic       rst_cpu_n,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       clk_slow,
  input logic       rst_slow_n,
  input logic       switch_en,
  input logic       fault_in,
  input logic       trip
);
  a_r3_busy_after_write: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    (wr_en && !busy) |=> busy);

  a_r4_hold_while_busy: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    busy |=> $stable(rd_data));

  a_r2_reserved_zero: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    (rd_data[7:6] == 2'b00));

  a_r8_off_clears_trip: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !switch_en |=> !trip);

  a_r8_trip_sticky: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    (trip && switch_en) |=> trip);

  a_r5_trip_needs_fault: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    $rose(trip) |-> $past(fault_in));

  a_r6_no_trip_on_enable: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    $rose(switch_en) |=> !trip);
endmodule

bind prot_delay_timer prot_delay_timer_chk u_chk (
  .clk_cpu(clk_cpu), .rst_cpu_n(rst_cpu_n), .wr_en(wr_en), .rd_data(rd_data),
  .busy(busy), .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
  .switch_en(switch_en), .fault_in(fault_in), .trip(trip)
);

// File: tb/prot_delay_timer_tb.sv
module prot_delay_timer_tb;
  localparam int STEP = 4;
  localparam int INIT = 3;

  logic       clk_cpu = 0, clk_slow = 0;
  logic       rst_cpu_n = 0, rst_slow_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       busy, trip;
  logic       switch_en = 0, fault_in = 0;

  int checks = 0, errors = 0;
  bit exp_acc = 0;
  int mreg = 1;
  int mpre = 0, men = 0, mrun = 0;
  bit mtrip = 0;
  int cyc = 0;

  prot_delay_timer #(.STEP_CYC(STEP), .INIT_CYC(INIT)) u_dut (
    .clk_cpu(clk_cpu), .rst_cpu_n(rst_cpu_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
    .switch_en(switch_en), .fault_in(fault_in), .trip(trip)
  );

  always #10 clk_cpu = ~clk_cpu;
  initial begin #7; forever #80 clk_slow = ~clk_slow; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model: CPU register
  always @(posedge clk_cpu) begin
    if (!rst_cpu_n) mreg = 1;
    else if (wr_en && exp_acc) mreg = wr_data & 8'h3F;
  end
  always @(negedge clk_cpu) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (rst_cpu_n) check(rd_data == 8'(mreg), "R2 R4 readback", rd_data, mreg);
  end

  // reference model: slow side
  always @(posedge clk_slow) begin
    if (!rst_slow_n) begin
      mpre = 0; men = 0; mrun = 0; mtrip = 0;
    end else begin
      automatic bit tk = (mpre == STEP - 1);
      automatic int e = (mreg < 2) ? 1 : mreg;
      mpre = tk ? 0 : mpre + 1;
      if (!switch_en) begin
        men = 0; mrun = 0; mtrip = 0;
      end else begin
        if (men >= INIT && !mtrip) begin
          if (!fault_in) mrun = 0;
          else if (tk) begin
            mrun++;
            if (mrun >= e) mtrip = 1;
          end
        end
        men++;
      end
    end
  end
  always @(negedge clk_slow)
    if (rst_slow_n) check(trip == mtrip, "R5 R6 R7 R8 trip model", trip, mtrip);

  task automatic cpu_write(input logic [7:0] d, input bit acc);
    @(negedge clk_cpu);
    wr_en = 1; wr_data = d; exp_acc = acc;
    @(negedge clk_cpu);
    wr_en = 0; exp_acc = 0;
  endtask

  task automatic set_code(input logic [7:0] d);
    cpu_write(d, 1);
    repeat (45) @(negedge clk_cpu);
  endtask

  task automatic measure(input logic [7:0] code, input string req);
    automatic int e = (code < 2) ? 1 : int'(code);
    automatic int n = 0;
    set_code(code);
    @(negedge clk_slow);
    switch_en = 1;
    repeat (INIT + 2) @(negedge clk_slow);
    fault_in = 1;
    while (!trip && n < 400) begin
      @(negedge clk_slow);
      n++;
    end
    check(n >= (e - 1) * STEP + 1 && n <= e * STEP, req, n, e * STEP);
    fault_in = 0;
    repeat (3) @(negedge clk_slow);
    check(trip == 1, "R8 trip holds after fault drop", trip, 1);
    switch_en = 0;
    @(negedge clk_slow);
    check(trip == 0, "R8 trip clears when switch off", trip, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_slow);
    rst_cpu_n = 1; rst_slow_n = 1;
    @(negedge clk_cpu);
    check(rd_data == 8'h01, "R1 reset code", rd_data, 1);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(trip == 0, "R1 reset trip", trip, 0);

    // R2, R3, R4
    cpu_write(8'hC2, 1);
    check(busy == 1, "R3 busy after write", busy, 1);
    check(rd_data == 8'h02, "R2 reserved bits masked", rd_data, 2);
    repeat (4) @(negedge clk_cpu);
    cpu_write(8'h15, 0);
    check(rd_data == 8'h02, "R4 write ignored while busy", rd_data, 2);
    repeat (12) @(negedge clk_cpu);
    check(busy == 1, "R3 guard still open", busy, 1);
    repeat (24) @(negedge clk_cpu);
    check(busy == 0, "R3 guard closed", busy, 0);
    cpu_write(8'hFF, 1);
    check(rd_data == 8'h3F, "R2 full code, reserved zero", rd_data, 8'h3F);
    repeat (45) @(negedge clk_cpu);

    // R5, R9 windows
    measure(8'h02, "R5 code 2 window");
    measure(8'h01, "R5 code 1 window");
    measure(8'h00, "R5 code 0 same as code 1");
    measure(8'h3F, "R9 top code window");

    // R7: short pulses never trip
    set_code(8'h02);
    @(negedge clk_slow);
    switch_en = 1;
    repeat (INIT + 2) @(negedge clk_slow);
    for (int p = 0; p < 8; p++) begin
      fault_in = 1;
      repeat (4) @(negedge clk_slow);
      fault_in = 0;
      @(negedge clk_slow);
    end
    check(trip == 0, "R7 restart on fault drop", trip, 0);
    switch_en = 0;
    @(negedge clk_slow);

    // R6: fault already high at enable
    set_code(8'h01);
    @(negedge clk_slow);
    fault_in = 1;
    switch_en = 1;
    for (int k = 0; k < INIT; k++) begin
      @(negedge clk_slow);
      check(trip == 0, "R6 disarmed during init", trip, 0);
    end
    repeat (STEP) @(negedge clk_slow);
    check(trip == 1, "R6 armed after init", trip, 1);
    fault_in = 0;
    switch_en = 0;
    repeat (2) @(negedge clk_slow);
    finish_run();
  end
endmodule